// File: doc/BRIEF.md
# Serial Configuration Loader for a Programmable Target

This block loads a configuration image into a programmable device through the device's slave-serial port. It takes the image as a byte stream with a valid/ready handshake and drives three lines: an active-low program line, a serial clock and a serial data line. It watches two status lines that the target drives: its init line and its done line. Both are passed through two-stage synchronisers before use.

A pulse on `start` begins a load. The block first drops incoming bytes until it sees a synchronisation pattern. `preambleSel` chooses which pattern, and it is captured when `start` is accepted. The block then clears the target. It pulls the program line low and waits for init to fall, then lets the program line go and waits for init to rise. After that it sends the pattern bytes, followed by the rest of the stream, one bit at a time. The byte flagged with `inLast` is the final one. The block then waits for done.

Each of the three waits has its own cycle-count limit and its own error code. The outcome stays on `okDone` and `errCode` until the next load begins.

Top module: `cfg_serial_loader`

## Requirements
- R1: `inReady` is high only while the block is searching for the pattern or asking for the next data byte. A byte is taken on a cycle where `inValid` and `inReady` are both high. `inReady` is low in idle and while the program line is low.
- R2: With `preambleSel`=0 the pattern is four consecutive 0xFF bytes. Every earlier byte is dropped, including a partial run of 0xFF. All four 0xFF bytes are sent to the target ahead of the data.
- R3: With `preambleSel`=1 the pattern is a 0xFF byte immediately followed by a byte whose bits [7:4] equal 0x3. Earlier bytes are dropped, and both pattern bytes are sent ahead of the data.
- R4: Once the pattern is found, `progN` goes low while `cclk` and `din` stay high, and no data bits are sent. If the synchronised init line has not fallen within `TMO_INIT_LOW` cycles, the load ends with `errCode`=1.
- R5: After init falls, `progN` returns high and the block waits for init to rise. If it has not risen within `TMO_INIT_HIGH` cycles, the load ends with `errCode`=2 and no data bits are sent.
- R6: Each bit runs through four phases of `CLK_DIV` clock cycles each, so the rising edges of `cclk` within a byte are 4·`CLK_DIV` cycles apart. The phases are: `cclk` low with `din` high, then `cclk` low with `din` equal to the bit, then `cclk` high with `din` still equal to the bit, then `cclk` high with `din` high. Bits leave most significant first.
- R7: The byte carrying `inLast` is the last one sent. This holds even when it is the final pattern byte. The block then waits for the synchronised done line. If done rises within `TMO_DONE` cycles, `okDone`=1. Otherwise `errCode`=3.
- R8: In idle, `progN`, `cclk` and `din` are all high and `busy` is low. `okDone` and `errCode` keep their values in idle. A `start` pulse while `busy` is high has no effect.
- R9: `okDone`=1 and a nonzero `errCode` never appear together. Both are cleared on the cycle after an accepted `start`, when `busy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load (accepted only in idle) |
| preambleSel | input | 1 | Pattern choice: 0 = four 0xFF, 1 = 0xFF then 0x3X |
| inData | input | 8 | Stream byte |
| inValid | input | 1 | Stream byte present |
| inLast | input | 1 | Stream byte is the final one |
| inReady | output | 1 | Block takes the presented byte |
| progN | output | 1 | Active-low program line to the target |
| cclk | output | 1 | Serial configuration clock to the target |
| din | output | 1 | Serial configuration data to the target |
| tgtInit | input | 1 | Target init line (asynchronous) |
| tgtDone | input | 1 | Target done line (asynchronous) |
| busy | output | 1 | A load is in progress |
| okDone | output | 1 | Last load completed with done seen |
| errCode | output | 2 | 0 none, 1 init did not fall, 2 init did not rise, 3 done did not rise |

## Verification
Some properties are checked on every cycle. The lines stay high in idle, and `cclk` and `din` stay high while the program line is low. `din` is stable at each `cclk` rise and high at each fall. The handshake is silent outside the stream phases. Success and error are never reported together, and the result is cleared and then held exactly as the start rule says. Other behaviour can only be shown by the bench's scenarios, with a reactive target model. These are: which bytes the pattern search drops or keeps in each mode, the order of the bits that arrive at the target, the spacing of the clock edges, the correct error code for each stalled wait, a pattern that ends the stream, and a start pulse that arrives mid-load.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_PROG,
    ST_INITWAIT,
    ST_SHIFT,
    ST_FETCH,
    ST_DONEWAIT
  } seqState_t;

  typedef enum logic [1:0] {
    WAIT_NONE,
    WAIT_INIT_LOW,
    WAIT_INIT_HIGH,
    WAIT_DONE
  } waitSel_t;

  localparam logic [1:0] ERR_NONE      = 2'd0;
  localparam logic [1:0] ERR_INIT_LOW  = 2'd1;
  localparam logic [1:0] ERR_INIT_HIGH = 2'd2;
  localparam logic [1:0] ERR_DONE      = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic              huntTake;   // pattern search looks at presented byte
    logic              modeLatch;  // capture pattern choice, clear matcher
    logic              progLow;    // hold program line low
    waitSel_t          waitSel;    // which wait the timeout counter times
    logic              load;       // start shifting loadVal
    logic [BYTE_W-1:0] loadVal;
  } ctrlCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic              initLvl;    // synchronised init line
    logic              doneLvl;    // synchronised done line
    logic              tmoHit;     // current wait has run out
    logic              preHit;     // presented byte completes the pattern
    logic              byteDone;   // last phase of last bit ends this cycle
    logic              shortMode;  // two-byte pattern selected
    logic [BYTE_W-1:0] tailByte;   // byte that completed the pattern
  } dpStat_t;

endpackage

// File: rtl/cfg_loader_sync.sv
module cfg_loader_sync #(
  parameter int                 WIDTH     = 2,
  parameter int                 STAGES    = 2,
  parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ[0] <= RESET_VAL;
    else       stageQ[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= RESET_VAL;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/cfg_loader_dp.sv
module cfg_loader_dp
  import cfg_loader_pkg::*;
#(
  parameter int          CLK_DIV       = 4,
  parameter int          TMO_INIT_LOW  = 300000,
  parameter int          TMO_INIT_HIGH = 300000,
  parameter int          TMO_DONE      = 300000,
  parameter int          PRE_LONG_LEN  = 4,
  parameter logic [3:0]  PRE_SHORT_TAG = 4'h3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlCmd_t          cmd,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              preambleSel,
  input  logic              tgtInit,
  input  logic              tgtDone,
  output dpStat_t           stat,
  output logic              progN,
  output logic              cclk,
  output logic              din
);

  localparam int TMO_AB  = (TMO_INIT_LOW > TMO_INIT_HIGH) ? TMO_INIT_LOW : TMO_INIT_HIGH;
  localparam int TMO_MAX = (TMO_AB > TMO_DONE) ? TMO_AB : TMO_DONE;
  localparam int TMO_W   = $clog2(TMO_MAX + 1);
  localparam int DIV_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int MATCH_W = $clog2(PRE_LONG_LEN + 1);
  localparam int BIT_W   = $clog2(BYTE_W);

  // ---------------- line synchronisers: {done, init}
  logic [1:0] pinSync;
  cfg_loader_sync #(.WIDTH(2), .STAGES(2), .RESET_VAL(2'b01)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({tgtDone, tgtInit}),
    .syncOut (pinSync)
  );

  // ---------------- shared timeout counter
  waitSel_t          waitQ;
  logic [TMO_W-1:0]  tmoCnt;
  logic [TMO_W-1:0]  limitVal;

  always_comb begin
    case (cmd.waitSel)
      WAIT_INIT_LOW:  limitVal = TMO_W'(TMO_INIT_LOW - 1);
      WAIT_INIT_HIGH: limitVal = TMO_W'(TMO_INIT_HIGH - 1);
      WAIT_DONE:      limitVal = TMO_W'(TMO_DONE - 1);
      default:        limitVal = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitQ  <= WAIT_NONE;
      tmoCnt <= '0;
    end else begin
      waitQ <= cmd.waitSel;
      if (cmd.waitSel != waitQ)           tmoCnt <= '0;
      else if (tmoCnt != TMO_W'(TMO_MAX)) tmoCnt <= tmoCnt + 1'b1;
    end
  end

  // ---------------- pattern matcher
  logic               modeQ;
  logic [MATCH_W-1:0] matchCnt;
  logic [BYTE_W-1:0]  tailQ;
  logic               take;
  logic               hit;
  logic               isFF;

  assign take = cmd.huntTake && inValid;
  assign isFF = (inData == {BYTE_W{1'b1}});

  always_comb begin
    if (modeQ) hit = take && (matchCnt != '0) && (inData[7:4] == PRE_SHORT_TAG);
    else       hit = take && (matchCnt == MATCH_W'(PRE_LONG_LEN - 1)) && isFF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= 1'b0;
      matchCnt <= '0;
      tailQ    <= '0;
    end else if (cmd.modeLatch) begin
      modeQ    <= preambleSel;
      matchCnt <= '0;
    end else if (take) begin
      if (hit) begin
        matchCnt <= '0;
        tailQ    <= inData;
      end else if (isFF) begin
        matchCnt <= modeQ ? MATCH_W'(1) : matchCnt + 1'b1;
      end else begin
        matchCnt <= '0;
      end
    end
  end

  // ---------------- bit engine: four phases per bit, CLK_DIV cycles each
  logic              active;
  logic [BYTE_W-1:0] shReg;
  logic [BIT_W-1:0]  bitIdx;
  logic [1:0]        phase;
  logic [DIV_W-1:0]  divCnt;
  logic              stepEnd;
  logic              lastStep;

  assign stepEnd  = active && (divCnt == DIV_W'(CLK_DIV - 1));
  assign lastStep = stepEnd && (phase == 2'd3) && (bitIdx == BIT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      shReg  <= '0;
      bitIdx <= '0;
      phase  <= '0;
      divCnt <= '0;
    end else if (cmd.load) begin
      active <= 1'b1;
      shReg  <= cmd.loadVal;
      bitIdx <= '0;
      phase  <= '0;
      divCnt <= '0;
    end else if (active) begin
      if (stepEnd) begin
        divCnt <= '0;
        phase  <= phase + 1'b1;
        if (phase == 2'd3) begin
          shReg  <= {shReg[BYTE_W-2:0], 1'b0};
          bitIdx <= bitIdx + 1'b1;
          if (bitIdx == BIT_W'(BYTE_W - 1)) active <= 1'b0;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // ---------------- registered target lines
  logic cclkNext;
  logic dinNext;

  assign cclkNext = !active || phase[1];
  assign dinNext  = !active || (phase == 2'd0) || (phase == 2'd3) || shReg[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progN <= 1'b1;
      cclk  <= 1'b1;
      din   <= 1'b1;
    end else begin
      progN <= !cmd.progLow;
      cclk  <= cclkNext;
      din   <= dinNext;
    end
  end

  // ---------------- status
  assign stat.initLvl   = pinSync[0];
  assign stat.doneLvl   = pinSync[1];
  assign stat.tmoHit    = (cmd.waitSel != WAIT_NONE) && (cmd.waitSel == waitQ) && (tmoCnt >= limitVal);
  assign stat.preHit    = hit;
  assign stat.byteDone  = lastStep;
  assign stat.shortMode = modeQ;
  assign stat.tailByte  = tailQ;

endmodule

// File: rtl/cfg_loader_ctrl.sv
module cfg_loader_ctrl
  import cfg_loader_pkg::*;
#(
  parameter int PRE_LONG_LEN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BYTE_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  input  dpStat_t           stat,
  output ctrlCmd_t          cmd,
  output logic              inReady,
  output logic              busy,
  output logic              okDone,
  output logic [1:0]        errCode
);

  localparam int RC_W = $clog2(PRE_LONG_LEN + 1);

  seqState_t         state;
  logic              lastSeen;
  logic [RC_W-1:0]   replayCnt;
  logic [RC_W-1:0]   preEnd;
  logic              replayMore;

  assign preEnd     = stat.shortMode ? RC_W'(2) : RC_W'(PRE_LONG_LEN);
  assign replayMore = (replayCnt < preEnd);
  assign inReady    = (state == ST_HUNT) || (state == ST_FETCH);
  assign busy       = (state != ST_IDLE);

  always_comb begin
    cmd         = '0;
    cmd.waitSel = WAIT_NONE;
    case (state)
      ST_IDLE:     cmd.modeLatch = start;
      ST_HUNT:     cmd.huntTake  = 1'b1;
      ST_PROG: begin
        cmd.progLow = 1'b1;
        cmd.waitSel = WAIT_INIT_LOW;
      end
      ST_INITWAIT: begin
        cmd.waitSel = WAIT_INIT_HIGH;
        if (stat.initLvl) begin
          cmd.load    = 1'b1;
          cmd.loadVal = {BYTE_W{1'b1}};
        end
      end
      ST_SHIFT: begin
        if (stat.byteDone && replayMore) begin
          cmd.load    = 1'b1;
          cmd.loadVal = (replayCnt == preEnd - 1'b1) ? stat.tailByte : {BYTE_W{1'b1}};
        end
      end
      ST_FETCH: begin
        if (inValid) begin
          cmd.load    = 1'b1;
          cmd.loadVal = inData;
        end
      end
      ST_DONEWAIT: cmd.waitSel = WAIT_DONE;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      lastSeen  <= 1'b0;
      replayCnt <= '0;
      okDone    <= 1'b0;
      errCode   <= ERR_NONE;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          okDone  <= 1'b0;
          errCode <= ERR_NONE;
          state   <= ST_HUNT;
        end
        ST_HUNT: if (stat.preHit) begin
          lastSeen <= inLast;
          state    <= ST_PROG;
        end
        ST_PROG: begin
          if (!stat.initLvl) state <= ST_INITWAIT;
          else if (stat.tmoHit) begin
            errCode <= ERR_INIT_LOW;
            state   <= ST_IDLE;
          end
        end
        ST_INITWAIT: begin
          if (stat.initLvl) begin
            replayCnt <= RC_W'(1);
            state     <= ST_SHIFT;
          end else if (stat.tmoHit) begin
            errCode <= ERR_INIT_HIGH;
            state   <= ST_IDLE;
          end
        end
        ST_SHIFT: if (stat.byteDone) begin
          if (replayMore)    replayCnt <= replayCnt + 1'b1;
          else if (lastSeen) state     <= ST_DONEWAIT;
          else               state     <= ST_FETCH;
        end
        ST_FETCH: if (inValid) begin
          lastSeen <= inLast;
          state    <= ST_SHIFT;
        end
        ST_DONEWAIT: begin
          if (stat.doneLvl) begin
            okDone <= 1'b1;
            state  <= ST_IDLE;
          end else if (stat.tmoHit) begin
            errCode <= ERR_DONE;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int         CLK_DIV       = 4,
  parameter int         TMO_INIT_LOW  = 300000,
  parameter int         TMO_INIT_HIGH = 300000,
  parameter int         TMO_DONE      = 300000,
  parameter int         PRE_LONG_LEN  = 4,
  parameter logic [3:0] PRE_SHORT_TAG = 4'h3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        preambleSel,
  input  logic [7:0]  inData,
  input  logic        inValid,
  input  logic        inLast,
  output logic        inReady,
  output logic        progN,
  output logic        cclk,
  output logic        din,
  input  logic        tgtInit,
  input  logic        tgtDone,
  output logic        busy,
  output logic        okDone,
  output logic [1:0]  errCode
);

  ctrlCmd_t cmd;
  dpStat_t  stat;

  cfg_loader_ctrl #(.PRE_LONG_LEN(PRE_LONG_LEN)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .inData  (inData),
    .inValid (inValid),
    .inLast  (inLast),
    .stat    (stat),
    .cmd     (cmd),
    .inReady (inReady),
    .busy    (busy),
    .okDone  (okDone),
    .errCode (errCode)
  );

  cfg_loader_dp #(
    .CLK_DIV       (CLK_DIV),
    .TMO_INIT_LOW  (TMO_INIT_LOW),
    .TMO_INIT_HIGH (TMO_INIT_HIGH),
    .TMO_DONE      (TMO_DONE),
    .PRE_LONG_LEN  (PRE_LONG_LEN),
    .PRE_SHORT_TAG (PRE_SHORT_TAG)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .inData      (inData),
    .inValid     (inValid),
    .preambleSel (preambleSel),
    .tgtInit     (tgtInit),
    .tgtDone     (tgtDone),
    .stat        (stat),
    .progN       (progN),
    .cclk        (cclk),
    .din         (din)
  );

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       inReady,
  input logic       busy,
  input logic       okDone,
  input logic [1:0] errCode,
  input logic       progN,
  input logic       cclk,
  input logic       din
);

  AST_READY_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> busy); // R1

  AST_READY_LOW_IN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !progN |-> !inReady); // R1

  AST_PROG_LINES_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !progN |-> (cclk && din)); // R4

  AST_DIN_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cclk) |-> $stable(din)); // R6

  AST_DIN_HIGH_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cclk) |-> din); // R6

  AST_IDLE_LINES_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> (progN && cclk && din)); // R8

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(errCode) && $stable(okDone))); // R8

  AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(okDone && (errCode != 2'd0))); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && !okDone && (errCode == 2'd0))); // R9

endmodule

bind cfg_serial_loader cfg_loader_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .inReady (inReady),
  .busy    (busy),
  .okDone  (okDone),
  .errCode (errCode),
  .progN   (progN),
  .cclk    (cclk),
  .din     (din)
);

// File: tb/tb_cfg_serial_loader.sv
`timescale 1ns/1ps
module tb_cfg_serial_loader;

  localparam int BDIV  = 2;
  localparam int T_LOW = 40;
  localparam int T_HI  = 60;
  localparam int T_DN  = 50;
  localparam logic [10:0] NEVER = 11'd1000;

  typedef struct packed {
    logic        mode;
    logic [10:0] lowD;
    logic [10:0] highD;
    logic [10:0] doneD;
    logic [1:0]  expErr;
    logic        expOk;
    logic        shortSt;
    logic        poke;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 11'd5, 11'd10, 11'd4,  2'd0, 1'b1, 1'b0, 1'b0},
    '{1'b1, 11'd3, 11'd7,  11'd9,  2'd0, 1'b1, 1'b0, 1'b0},
    '{1'b0, NEVER, 11'd10, 11'd4,  2'd1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 11'd5, NEVER,  11'd4,  2'd2, 1'b0, 1'b0, 1'b0},
    '{1'b0, 11'd5, 11'd10, NEVER,  2'd3, 1'b0, 1'b0, 1'b0},
    '{1'b1, 11'd8, 11'd20, 11'd2,  2'd0, 1'b1, 1'b1, 1'b0},
    '{1'b0, 11'd5, 11'd10, 11'd4,  2'd0, 1'b1, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic preambleSel = 1'b0;
  logic [7:0] inData = 8'h00;
  logic inValid = 1'b0;
  logic inLast = 1'b0;
  logic inReady, progN, cclk, din, busy, okDone;
  logic [1:0] errCode;
  logic tgtInit = 1'b1;
  logic tgtDone = 1'b0;

  always #2.5 clk = ~clk;

  cfg_serial_loader #(
    .CLK_DIV(BDIV), .TMO_INIT_LOW(T_LOW), .TMO_INIT_HIGH(T_HI), .TMO_DONE(T_DN)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .preambleSel(preambleSel),
    .inData(inData), .inValid(inValid), .inLast(inLast), .inReady(inReady),
    .progN(progN), .cclk(cclk), .din(din), .tgtInit(tgtInit), .tgtDone(tgtDone),
    .busy(busy), .okDone(okDone), .errCode(errCode)
  );

  int testCnt = 0;
  int failCnt = 0;
  int cyc = 0;

  // target model state
  int lowDly, highDly, doneDly;
  int loCnt, hiCnt, doneCnt;
  bit sawProg;
  logic [7:0] capBuf [32];
  int capN, nBits, lastRise, minP, maxP, dinBad, readyBad;
  logic [7:0] bitAcc;

  logic [7:0] sendBuf [16];
  logic [7:0] expBuf [16];
  int sendN, expN;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (!progN) begin
      sawProg = 1'b1;
      hiCnt = 0;
      if (loCnt >= lowDly) tgtInit = 1'b0;
      loCnt++;
      if (inReady) readyBad++;
    end else begin
      loCnt = 0;
      if (sawProg) begin
        if (hiCnt >= highDly) tgtInit = 1'b1;
        hiCnt++;
      end
    end
    if (expN > 0 && capN >= expN) begin
      if (doneCnt >= doneDly) tgtDone = 1'b1;
      doneCnt++;
    end
  end

  always @(posedge cclk) begin
    if (nBits != 0) begin
      if (cyc - lastRise < minP) minP = cyc - lastRise;
      if (cyc - lastRise > maxP) maxP = cyc - lastRise;
    end
    lastRise = cyc;
    bitAcc = {bitAcc[6:0], din};
    nBits++;
    if (nBits == 8) begin
      if (capN < 32) capBuf[capN] = bitAcc;
      capN++;
      nBits = 0;
    end
  end

  always @(negedge cclk) if (!din) dinBad++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pushS(input logic [7:0] b);
    sendBuf[sendN] = b;
    sendN++;
  endtask

  task automatic pushE(input logic [7:0] b);
    expBuf[expN] = b;
    expN++;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic l);
    @(negedge clk);
    inData = b; inValid = 1'b1; inLast = l;
    while (!inReady && busy) @(negedge clk);
    if (busy) @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic runCase(input vec_t v);
    int waitN;
    int payStart;
    string preReq;
    preReq = v.mode ? "R3" : "R2";
    lowDly = int'(v.lowD); highDly = int'(v.highD); doneDly = int'(v.doneD);
    loCnt = 0; hiCnt = 0; doneCnt = 0; sawProg = 1'b0;
    tgtInit = 1'b1; tgtDone = 1'b0;
    capN = 0; nBits = 0; minP = 1000000; maxP = 0; dinBad = 0; readyBad = 0;
    sendN = 0; expN = 0;
    if (v.shortSt) begin
      pushS(8'h20); pushS(8'hFF); pushS(8'h3F);
      pushE(8'hFF); pushE(8'h3F);
    end else if (!v.mode) begin
      pushS(8'h12); pushS(8'hFF); pushS(8'hFF); pushS(8'hFF); pushS(8'h00);
      pushS(8'hFF); pushS(8'hFF); pushS(8'hFF); pushS(8'hFF);
      pushS(8'hA5); pushS(8'h3C); pushS(8'h81);
      pushE(8'hFF); pushE(8'hFF); pushE(8'hFF); pushE(8'hFF);
      pushE(8'hA5); pushE(8'h3C); pushE(8'h81);
    end else begin
      pushS(8'h37); pushS(8'hFF); pushS(8'h4F); pushS(8'hFF); pushS(8'hFF); pushS(8'h3A);
      pushS(8'hA5); pushS(8'h3C); pushS(8'h81);
      pushE(8'hFF); pushE(8'h3A);
      pushE(8'hA5); pushE(8'h3C); pushE(8'h81);
    end
    payStart = v.shortSt ? sendN : sendN - 3;

    @(negedge clk);
    preambleSel = v.mode; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy && errCode == 2'd0 && !okDone, "R9 cleared at start", {busy, errCode, okDone}, 4'b1000);

    for (int i = 0; i < sendN; i++) begin
      if (v.poke && i == payStart) begin
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
      end
      sendByte(sendBuf[i], (i == sendN - 1));
    end

    waitN = 0;
    while (busy && waitN < 3000) begin
      @(negedge clk);
      waitN++;
    end
    check(!busy, "R7 load finishes", busy, 0);
    check(errCode == v.expErr,
          (v.expErr == 2'd1) ? "R4 error code" : (v.expErr == 2'd2) ? "R5 error code" :
          (v.expErr == 2'd3) ? "R7 error code" : "R9 error code",
          errCode, v.expErr);
    check(okDone == v.expOk, v.poke ? "R8 start ignored while busy" : "R7 done result",
          okDone, v.expOk);
    check(readyBad == 0, "R1 ready low while clearing", readyBad, 0);
    if (v.expErr == 2'd0 || v.expErr == 2'd3) begin
      check(capN == expN, v.shortSt ? "R7 pattern ends stream" : preReq, capN, expN);
      for (int k = 0; k < expN; k++)
        check(capBuf[k] == expBuf[k], {preReq, " R6 byte content"}, capBuf[k], expBuf[k]);
      check(minP == 4 * BDIV && maxP == 4 * BDIV, "R6 bit period", maxP, 4 * BDIV);
      check(dinBad == 0, "R6 din high at clock fall", dinBad, 0);
    end else begin
      check(capN == 0 && nBits == 0, (v.expErr == 2'd1) ? "R4 no bits" : "R5 no bits",
            capN * 8 + nBits, 0);
    end
    repeat (2) @(negedge clk);
    check(progN && cclk && din && !inReady, "R8 idle lines high",
          {progN, cclk, din, inReady}, 4'b1110);
    repeat (5) @(negedge clk);
    check(errCode == v.expErr && okDone == v.expOk, "R8 result held in idle",
          {errCode, okDone}, {v.expErr, v.expOk});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin : main
    lowDly = 0; highDly = 0; doneDly = 0; expN = 0; capN = 0;
    repeat (4) @(negedge clk);
    check(progN && cclk && din, "R8 lines high in reset", {progN, cclk, din}, 3'b111);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !okDone && errCode == 2'd0, "R8 reset status", {busy, okDone, errCode}, 0);
    check(!inReady, "R1 not ready in idle", inReady, 0);
    // bytes presented in idle are not taken
    inData = 8'hFF; inValid = 1'b1;
    repeat (3) @(negedge clk);
    check(!inReady && !busy, "R1 idle ignores stream", {inReady, busy}, 0);
    inValid = 1'b0;

    for (int r = 0; r < NVEC; r++) runCase(VECS[r]);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule